// File: doc/BRIEF.md
# Soft-Mute Ramp and Settings-Change Sequencer

This block produces the gain coefficient that a downstream multiplier applies to processed audio. The coefficient moves one step per sample strobe between full silence (0) and unity (2^RAMP_BITS), so gain changes are always gradual. An active-low mute input selects the direction of the ramp. Reversing that input part-way through a ramp turns the ramp around from wherever it stands.

The block also owns the moment at which new processing settings take effect. These settings are a compression-curve selector and an attack-filter selector. A new input value counts only after it has been seen on STABLE_FS consecutive strobes. If the output is not already silent, the sequencer first ramps the coefficient down to zero and ignores the mute input while it does so. It then issues a one-cycle apply pulse, latches the new settings onto its outputs, and ramps back up if mute is released. If the coefficient is already zero, the settings are applied at once. After reset, an initialization phase of INIT_FS strobes holds the coefficient at silence. That phase ends with one apply pulse.

The state machine has four states. ST_INIT is the forced-silent initialization. ST_TRACK follows the mute input. ST_DRAIN is the forced ramp-down before a settings change. ST_APPLY is the one-cycle latch. The transitions are:
- T_INIT_DONE: INIT→APPLY, on the INIT_FS-th strobe.
- T_DRAIN_START: TRACK→DRAIN, when a settings change is pending and the coefficient is above zero.
- T_DIRECT_APPLY: TRACK→APPLY, when a settings change is pending and the coefficient is zero.
- T_DRAIN_DONE: DRAIN→APPLY, when the coefficient reaches zero.
- T_RESUME: APPLY→TRACK, always.

Top module: `smr_soft_mute`

## Requirements
- R1: While rst_n is low, coef_o is 0, apply_o is 0, and mode_o and atk_sel_o are 0.
- R2: After reset is released, coef_o stays 0 for INIT_FS strobes. On the INIT_FS-th strobe, one apply pulse latches the settings inputs, and the ramp starts from 0 afterwards.
- R3: In tracking with mute_n_i high, coef_o rises by exactly 1 on each strobe and saturates at unity (2^RAMP_BITS). A full ramp therefore takes 2^RAMP_BITS strobes.
- R4: In tracking with mute_n_i low, coef_o falls by exactly 1 on each strobe and saturates at 0.
- R5: A change of mute_n_i during a ramp reverses the direction on the next strobe, starting from the current coefficient.
- R6: A settings value (mode_i with atk_sel_i) is recognized only when it has been sampled on STABLE_FS consecutive strobes. A shorter excursion causes no apply pulse, no output change and no coefficient change.
- R7: When a recognized change is pending and coef_o is above 0, coef_o falls by 1 per strobe regardless of mute_n_i. Once it reads 0, one apply pulse follows. mode_o and atk_sel_o take the new value in the cycle after that pulse, and change at no other time.
- R8: When a recognized change is pending and coef_o is already 0, the apply pulse follows within two clock cycles. coef_o stays 0 and no ramp takes place.
- R9: After an apply pulse, the coefficient ramps up only if mute_n_i is high. If mute_n_i is low, it stays at 0.
- R10: coef_o never exceeds 2^RAMP_BITS and changes only in the cycle after a strobe, by at most 1.
- R11: apply_o is never high on two consecutive cycles, and is high only while coef_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_stb_i | input | 1 | One-cycle pulse once per sample period |
| mute_n_i | input | 1 | Mute request, active low |
| mode_i | input | MODE_W (3) | Requested compression-curve selector |
| atk_sel_i | input | 1 | Requested attack-filter selector |
| coef_o | output | RAMP_BITS+1 | Attenuation coefficient, 0 = silent, 2^RAMP_BITS = unity |
| apply_o | output | 1 | One-cycle pulse when new settings are latched |
| mode_o | output | MODE_W (3) | Curve selector currently in effect |
| atk_sel_o | output | 1 | Attack selector currently in effect |

## Verification
The bench uses an eight-step ramp to reach the saturation points and to reverse the ramp at several positions. A counter that stepped past unity would show up at the saturation checks, and so would one that wrapped below zero or restarted a reversed ramp from an end point. A settings change is started from every coefficient value. This tests that the drain length matches the starting position and that the apply pulse waits for true silence; a design that applied early, or that let mute_n_i pull the drain back up, would fail these checks. All sixteen settings codes are stepped through while the output is muted, so each must apply with no ramp. A single-strobe glitch must leave the outputs alone. An apply that happens while mute is still held low must not start an unmute ramp.

// File: rtl/smr_pkg.sv
package smr_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_TRACK = 2'd1,
        ST_DRAIN = 2'd2,
        ST_APPLY = 2'd3
    } smr_state_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              atk;
    } smr_set_t;

    localparam int SET_W = $bits(smr_set_t);
endpackage

// File: rtl/smr_set_filter.sv
// Accepts a settings word only after it has been sampled unchanged on
// STABLE_FS consecutive strobes.
module smr_set_filter #(
    parameter int W         = 4,
    parameter int STABLE_FS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] raw,
    output logic [W-1:0] stable
);
    localparam int CW = $clog2(STABLE_FS + 1);
    localparam logic [CW-1:0] LIM = CW'(STABLE_FS);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [W-1:0]  cand_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        if (raw != cand_q) begin
            cnt_nxt = ONE;
        end else if (cnt_q >= LIM) begin
            cnt_nxt = LIM;
        end else begin
            cnt_nxt = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= '0;
            cnt_q  <= '0;
            stable <= '0;
        end else if (stb) begin
            cand_q <= raw;
            cnt_q  <= cnt_nxt;
            if (cnt_nxt >= LIM) begin
                stable <= raw;
            end
        end
    end
endmodule

// File: rtl/smr_ramp_ctr.sv
// Saturating up/down position counter; unity is 2^RAMP_BITS.
module smr_ramp_ctr #(
    parameter int RAMP_BITS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               up,
    input  logic               clr,
    output logic [RAMP_BITS:0] pos,
    output logic               at_zero
);
    localparam int PW = RAMP_BITS + 1;
    localparam logic [PW-1:0] FULL = PW'(1) << RAMP_BITS;
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic [PW-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clr) begin
            pos_q <= '0;
        end else if (step) begin
            if (up && pos_q < FULL) begin
                pos_q <= pos_q + ONE;
            end else if (!up && pos_q != '0) begin
                pos_q <= pos_q - ONE;
            end
        end
    end

    assign pos     = pos_q;
    assign at_zero = (pos_q == '0);
endmodule

// File: rtl/smr_seq_fsm.sv
// Sequencer: init silence, mute tracking, forced drain, settings apply.
module smr_seq_fsm
    import smr_pkg::*;
#(
    parameter int INIT_FS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic mute_n,
    input  logic pending,
    input  logic at_zero,
    output logic step_en,
    output logic dir_up,
    output logic clr_pos,
    output logic apply,
    output logic silent
);
    localparam int ICW = $clog2(INIT_FS + 1);
    localparam logic [ICW-1:0] ILAST = ICW'(INIT_FS - 1);

    smr_state_e    state_q;
    smr_state_e    state_nxt;
    logic [ICW-1:0] icnt_q;
    logic           init_done;

    assign init_done = stb && (icnt_q == ILAST);

    // State register and the init-phase strobe counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            icnt_q  <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_q != ST_INIT) begin
                icnt_q <= '0;
            end else if (stb) begin
                icnt_q <= icnt_q + ICW'(1);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_INIT: begin
                if (init_done) state_nxt = ST_APPLY;          // T_INIT_DONE
            end
            ST_TRACK: begin
                if (pending) begin
                    if (at_zero) state_nxt = ST_APPLY;        // T_DIRECT_APPLY
                    else         state_nxt = ST_DRAIN;        // T_DRAIN_START
                end
            end
            ST_DRAIN: begin
                if (at_zero) state_nxt = ST_APPLY;            // T_DRAIN_DONE
            end
            ST_APPLY: begin
                state_nxt = ST_TRACK;                         // T_RESUME
            end
        endcase
    end

    // Output logic
    always_comb begin
        step_en = 1'b0;
        dir_up  = 1'b0;
        clr_pos = 1'b0;
        apply   = 1'b0;
        silent  = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                clr_pos = 1'b1;
                silent  = 1'b1;
            end
            ST_TRACK: begin
                step_en = stb && !pending;
                dir_up  = mute_n;
            end
            ST_DRAIN: begin
                step_en = stb;
                dir_up  = 1'b0;
            end
            ST_APPLY: begin
                apply = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/smr_soft_mute.sv
module smr_soft_mute
    import smr_pkg::*;
#(
    parameter int RAMP_BITS = 10,
    parameter int INIT_FS   = 4,
    parameter int STABLE_FS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fs_stb_i,
    input  logic                 mute_n_i,
    input  logic [MODE_W-1:0]    mode_i,
    input  logic                 atk_sel_i,
    output logic [RAMP_BITS:0]   coef_o,
    output logic                 apply_o,
    output logic [MODE_W-1:0]    mode_o,
    output logic                 atk_sel_o
);
    smr_set_t       raw_set;
    smr_set_t       stable_set;
    smr_set_t       applied_q;
    logic           pending;
    logic           step_en;
    logic           dir_up;
    logic           clr_pos;
    logic           apply;
    logic           silent;
    logic           at_zero;
    logic [RAMP_BITS:0] pos;

    assign raw_set.mode = mode_i;
    assign raw_set.atk  = atk_sel_i;

    smr_set_filter #(
        .W         (SET_W),
        .STABLE_FS (STABLE_FS)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (fs_stb_i),
        .raw    (raw_set),
        .stable (stable_set)
    );

    assign pending = (stable_set != applied_q);

    smr_seq_fsm #(
        .INIT_FS (INIT_FS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (fs_stb_i),
        .mute_n  (mute_n_i),
        .pending (pending),
        .at_zero (at_zero),
        .step_en (step_en),
        .dir_up  (dir_up),
        .clr_pos (clr_pos),
        .apply   (apply),
        .silent  (silent)
    );

    smr_ramp_ctr #(
        .RAMP_BITS (RAMP_BITS)
    ) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step_en),
        .up      (dir_up),
        .clr     (clr_pos),
        .pos     (pos),
        .at_zero (at_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            applied_q <= '0;
        end else if (apply) begin
            applied_q <= stable_set;
        end
    end

    assign coef_o    = silent ? '0 : pos;
    assign apply_o   = apply;
    assign mode_o    = applied_q.mode;
    assign atk_sel_o = applied_q.atk;
endmodule

// File: rtl/smr_soft_mute_chk.sv
module smr_soft_mute_chk
    import smr_pkg::*;
#(
    parameter int RAMP_BITS = 10,
    parameter int INIT_FS   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fs_stb_i,
    input logic [RAMP_BITS:0] coef_o,
    input logic               apply_o,
    input logic [MODE_W-1:0]  mode_o,
    input logic               atk_sel_o
);
    localparam int PW  = RAMP_BITS + 1;
    localparam int ICW = $clog2(INIT_FS + 1);
    localparam logic [PW-1:0]  FULL = PW'(1) << RAMP_BITS;
    localparam logic [ICW-1:0] ILIM = ICW'(INIT_FS);

    logic [ICW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (fs_stb_i && seen_q < ILIM) begin
            seen_q <= seen_q + ICW'(1);
        end
    end

    a_r2_init_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q < ILIM) |-> (coef_o == '0));

    a_r10_coef_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        coef_o <= FULL);

    a_r10_quiet_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fs_stb_i) |-> $stable(coef_o));

    a_r10_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_o == $past(coef_o)) || (coef_o == $past(coef_o) + PW'(1))
        || (coef_o + PW'(1) == $past(coef_o)));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> !apply_o);

    a_r11_apply_silent: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |-> (coef_o == '0));

    a_r7_settings_only_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(apply_o) |-> ($stable(mode_o) && $stable(atk_sel_o)));
endmodule

bind smr_soft_mute smr_soft_mute_chk #(
    .RAMP_BITS (RAMP_BITS),
    .INIT_FS   (INIT_FS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_stb_i  (fs_stb_i),
    .coef_o    (coef_o),
    .apply_o   (apply_o),
    .mode_o    (mode_o),
    .atk_sel_o (atk_sel_o)
);

// File: tb/tb_smr_soft_mute.sv
module tb_smr_soft_mute;
    localparam int RB   = 3;
    localparam int FULL = 1 << RB;
    localparam int INIT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fs_stb_i = 1'b0;
    logic          mute_n_i = 1'b1;
    logic [2:0]    mode_i = 3'b101;
    logic          atk_sel_i = 1'b1;
    logic [RB:0]   coef_o;
    logic          apply_o;
    logic [2:0]    mode_o;
    logic          atk_sel_o;

    int nvec = 0;
    int nfail = 0;
    int apply_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    smr_soft_mute #(
        .RAMP_BITS (RB),
        .INIT_FS   (INIT),
        .STABLE_FS (2)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_stb_i  (fs_stb_i),
        .mute_n_i  (mute_n_i),
        .mode_i    (mode_i),
        .atk_sel_i (atk_sel_i),
        .coef_o    (coef_o),
        .apply_o   (apply_o),
        .mode_o    (mode_o),
        .atk_sel_o (atk_sel_o)
    );

    always @(negedge clk) if (rst_n && apply_o) apply_cnt++;

    task automatic check(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // One sample strobe, then enough idle cycles for any apply to finish.
    task automatic tick();
        @(negedge clk) fs_stb_i = 1'b1;
        @(negedge clk) fs_stb_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    initial begin
        int base;
        int q;
        int cur;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 coef", int'(coef_o), 0);
        check("R1 apply", int'(apply_o), 0);
        check("R1 mode", int'(mode_o), 0);
        check("R1 atk", int'(atk_sel_o), 0);
        rst_n = 1'b1;

        // R2: silent init then one apply
        for (int k = 1; k < INIT; k++) begin
            tick();
            check("R2 init silent", int'(coef_o), 0);
        end
        tick();
        check("R2 init coef", int'(coef_o), 0);
        check("R2 init apply count", apply_cnt, 1);
        check("R2 init mode", int'(mode_o), 5);
        check("R2 init atk", int'(atk_sel_o), 1);

        // R3: ramp up with saturation
        for (int k = 1; k <= FULL + 2; k++) begin
            tick();
            check("R3 up", int'(coef_o), imin(k, FULL));
        end
        // R4: ramp down with saturation
        mute_n_i = 1'b0;
        for (int k = 1; k <= FULL + 2; k++) begin
            tick();
            check("R4 down", int'(coef_o), (FULL - k > 0) ? FULL - k : 0);
        end
        // R5: reversals
        mute_n_i = 1'b1;
        repeat (5) tick();
        check("R5 up to 5", int'(coef_o), 5);
        mute_n_i = 1'b0;
        repeat (2) tick();
        check("R5 reverse down", int'(coef_o), 3);
        mute_n_i = 1'b1;
        repeat (3) tick();
        check("R5 reverse up", int'(coef_o), 6);
        repeat (2) tick();
        check("R5 at unity", int'(coef_o), FULL);

        // R6: single-strobe glitch ignored
        base = apply_cnt;
        mode_i = 3'b010;
        tick();
        mode_i = 3'b101;
        repeat (3) tick();
        check("R6 glitch apply", apply_cnt, base);
        check("R6 glitch mode", int'(mode_o), 5);
        check("R6 glitch coef", int'(coef_o), FULL);

        // R7: drain from unity with mute high, then apply
        mode_i = 3'b010;
        tick();
        check("R6 not yet", int'(mode_o), 5);
        tick();
        check("R7 drain start", int'(coef_o), FULL);
        for (int j = 1; j <= FULL; j++) begin
            tick();
            check("R7 drain", int'(coef_o), FULL - j);
            if (j < FULL) check("R7 old mode held", int'(mode_o), 5);
        end
        check("R7 applied mode", int'(mode_o), 2);
        check("R7 apply count", apply_cnt, base + 1);
        tick();
        check("R9 resume up", int'(coef_o), 1);
        repeat (FULL - 1) tick();
        check("R3 back at unity", int'(coef_o), FULL);

        // R9: mute low at apply time keeps silence
        atk_sel_i = 1'b0;
        repeat (2) tick();
        mute_n_i = 1'b0;
        repeat (FULL) tick();
        check("R9 atk applied", int'(atk_sel_o), 0);
        repeat (3) tick();
        check("R9 stays silent", int'(coef_o), 0);

        // R8: every settings code applied immediately while silent
        cur = {mode_o, atk_sel_o};
        for (int v = 0; v < 16; v++) begin
            base = apply_cnt;
            {mode_i, atk_sel_i} = 4'(v);
            tick();
            check("R8 not before filter", {mode_o, atk_sel_o}, cur);
            tick();
            check("R8 applied", int'({mode_o, atk_sel_o}), v);
            check("R8 apply count", apply_cnt, base + ((v != cur) ? 1 : 0));
            check("R8 no ramp", int'(coef_o), 0);
            cur = v;
        end

        // R7: drain from every starting position
        mute_n_i = 1'b1;
        for (int p = 1; p <= FULL; p++) begin
            repeat (p) tick();
            check("R3 reach p", int'(coef_o), p);
            base = apply_cnt;
            cur = (cur + 5) % 16;
            {mode_i, atk_sel_i} = 4'(cur);
            repeat (2) tick();
            q = imin(p + 2, FULL);
            check("R7 drain top", int'(coef_o), q);
            repeat (q - 1) tick();
            check("R7 one above", int'(coef_o), 1);
            check("R7 no early apply", apply_cnt, base);
            tick();
            check("R7 reached zero", int'(coef_o), 0);
            check("R7 applied once", apply_cnt, base + 1);
            check("R7 outputs", int'({mode_o, atk_sel_o}), cur);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule